// File: doc/BRIEF.md
# Executed-Address History Ring

This block keeps a short history of where a processor has been running. Each time the core finishes an instruction it pulses a strobe along with that instruction's address. Outside debug mode the block files each address into a five-slot ring, so the ring always holds the five most recent executed addresses.

When the processor drops into debug mode, capture stops and the ring is frozen. A debugger then reads the ring through a single shared read port. Every read returns one slot and moves a read pointer on to the next slot. The pointer is realigned at the moment debug mode is entered, so the first read returns the oldest entry and the fifth read returns the most recent one. Because of this, five reads always bring the pointer back to where it began.

At debug entry the block also freezes two companion values: the last fetched address and the address currently in the instruction latch. All strobes are single-cycle pulses with no back-pressure. The read port is always ready, and the read data reflects the slot that the strobe consumes in that same cycle.

Top module: `pab_history`

## Requirements
- R1: During reset, every slot, both pointers and both frozen registers are zero, and `rd_data` reads 0. The ring has exactly five slots, and each pointer counts 0,1,2,3,4 and then wraps back to 0.
- R2: A cycle in which `dbg_mode` is low and `exec_valid` is high stores `exec_addr` at the write position and advances the write position by one, with wrap.
- R3: While `dbg_mode` is high, `exec_valid` is ignored. No slot changes and the write position holds.
- R4: Debug entry is the first cycle in which `dbg_mode` is high after it was low or after reset. On entry the read pointer is set to the write position. As a result, successive reads return the slots from oldest to newest, and the newest slot is the last address executed before entry.
- R5: `rd_data` always shows the slot under the read pointer. In the entry cycle it shows the slot under the write position instead. A `rd_en` pulse advances the read pointer by one, with wrap, at that clock edge. This includes a read made in the entry cycle, which returns the oldest slot and leaves the pointer on the next one.
- R6: Five consecutive reads leave the read pointer where it started, so the sixth read returns the same value as the first.
- R7: In the entry cycle, `fetch_hold` captures `fetch_addr` and `decode_hold` captures `latch_addr`. In every other cycle both registers hold their value, including across reads and executed strobes made in debug mode.
- R8: In a cycle that is neither a read nor a debug entry, the read pointer does not move, and `rd_data` stays unchanged as long as no slot is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_valid | input | 1 | Instruction-executed strobe |
| exec_addr | input | 32 | Address of the executed instruction |
| dbg_mode | input | 1 | High while the processor is in debug mode |
| fetch_addr | input | 32 | Current fetch address |
| latch_addr | input | 32 | Address held in the instruction latch |
| rd_en | input | 1 | Read strobe; consumes one slot |
| rd_data | output | 32 | Slot returned by the current read |
| fetch_hold | output | 32 | Fetch address frozen at debug entry |
| decode_hold | output | 32 | Latch address frozen at debug entry |

## Verification
The two functions that can fall in the same cycle are realigning the read pointer at debug entry and consuming a read. A third event, an executed strobe, can also coincide with the entry cycle and must be ignored. The bench raises `dbg_mode` in the same cycle that it pulses `rd_en` and `exec_valid`, in directed cases and also at random points in the random phases. The outcome is judged by the value returned in that cycle, which must be the oldest slot, and by the following four reads, which must return the rest in order with the stray strobe absent.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Wrapping increment for a pointer over 0..depth-1.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/hist_ptr.sv
module hist_ptr #(
  parameter int DEPTH = 5,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  logic [PW-1:0] base;
  logic [PW-1:0] nxt;

  always_comb begin
    base = load ? load_val : ptr;
    nxt  = step ? PW'(hist_pkg::wrap_inc(int'(base), DEPTH)) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= nxt;
  end
endmodule

// File: rtl/hist_store.sv
module hist_store #(
  parameter int DEPTH = 5,
  parameter int AW    = 32,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wa,
  input  logic [AW-1:0] wd,
  input  logic [PW-1:0] ra,
  output logic [AW-1:0] rd
);
  logic [AW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       slot[i] <= '0;
      else if (we && wa == PW'(i))      slot[i] <= wd;
    end
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ra == PW'(i)) rd = slot[i];
  end
endmodule

// File: rtl/hist_snap.sv
module hist_snap #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_mode,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] latch_addr,
  output logic          entry,
  output logic [AW-1:0] fetch_hold,
  output logic [AW-1:0] decode_hold
);
  logic dbg_q;

  assign entry = dbg_mode && !dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q       <= 1'b0;
      fetch_hold  <= '0;
      decode_hold <= '0;
    end else begin
      dbg_q <= dbg_mode;
      if (entry) begin
        fetch_hold  <= fetch_addr;
        decode_hold <= latch_addr;
      end
    end
  end
endmodule

// File: rtl/pab_history.sv
module pab_history #(
  parameter int DEPTH = 5,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_valid,
  input  logic [AW-1:0] exec_addr,
  input  logic          dbg_mode,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] latch_addr,
  input  logic          rd_en,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] fetch_hold,
  output logic [AW-1:0] decode_hold
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          entry;
  logic          wr_go;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] rd_idx;

  assign wr_go  = exec_valid && !dbg_mode;
  assign rd_idx = entry ? wr_ptr : rd_ptr;

  hist_snap #(.AW(AW)) u_snap (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
    .fetch_addr(fetch_addr), .latch_addr(latch_addr),
    .entry(entry), .fetch_hold(fetch_hold), .decode_hold(decode_hold)
  );

  hist_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
    .step(wr_go), .ptr(wr_ptr)
  );

  hist_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
    .clk(clk), .rst_n(rst_n), .load(entry), .load_val(wr_ptr),
    .step(rd_en), .ptr(rd_ptr)
  );

  hist_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_go), .wa(wr_ptr), .wd(exec_addr),
    .ra(rd_idx), .rd(rd_data)
  );
endmodule

// File: rtl/hist_chk.sv
module hist_chk #(
  parameter int DEPTH = 5,
  parameter int AW    = 32,
  parameter int PW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_mode,
  input logic          rd_en,
  input logic          entry,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [AW-1:0] fetch_hold,
  input logic [AW-1:0] decode_hold
);
  // R1
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_ptr) < DEPTH);
  // R1
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_ptr) < DEPTH);
  // R3
  frozen_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> $stable(wr_ptr));
  // R4
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry && !rd_en |=> rd_ptr == $past(wr_ptr));
  // R5
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !entry |=> rd_ptr == (($past(rd_ptr) == PW'(DEPTH-1)) ? '0 : PW'($past(rd_ptr) + 1'b1)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !entry |=> $stable(fetch_hold) && $stable(decode_hold));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !entry |=> $stable(rd_ptr));
endmodule

bind pab_history hist_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_hist_chk (
  .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .rd_en(rd_en),
  .entry(entry), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .fetch_hold(fetch_hold), .decode_hold(decode_hold)
);

// File: tb/tb_pab_history.sv
module tb_pab_history;
  localparam int D = 5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        exec_valid = 0;
  logic [31:0] exec_addr = 0;
  logic        dbg_mode = 0;
  logic [31:0] fetch_addr = 0;
  logic [31:0] latch_addr = 0;
  logic        rd_en = 0;
  logic [31:0] rd_data, fetch_hold, decode_hold;

  int checks = 0, fails = 0;
  logic [31:0] m_slot [D];
  int m_wp = 0, m_rp = 0;
  logic m_dq = 0;
  logic [31:0] m_fh = 0, m_dh = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pab_history dut (.*);

  function automatic int inc(input int p);
    return (p + 1 >= D) ? 0 : p + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational read data, then apply model at edge.
  task automatic cyc(input bit ex, input logic [31:0] a, input bit dbg, input bit rd,
                     input logic [31:0] f, input logic [31:0] l);
    bit ent;
    @(negedge clk);
    chk("R7 fetch_hold", fetch_hold, m_fh);
    chk("R7 decode_hold", decode_hold, m_dh);
    exec_valid = ex; exec_addr = a; dbg_mode = dbg; rd_en = rd;
    fetch_addr = f; latch_addr = l;
    #1;
    ent = dbg && !m_dq;
    chk(ent ? "R4/R5 entry read" : "R5/R8 read data", rd_data, ent ? m_slot[m_wp] : m_slot[m_rp]);
    if (ex && !dbg) begin m_slot[m_wp] = a; m_wp = inc(m_wp); end
    if (ent) begin m_rp = m_wp; m_fh = f; m_dh = l; end
    if (rd) m_rp = inc(m_rp);
    m_dq = dbg;
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] first;
    void'($urandom(32'd2024));
    for (int i = 0; i < D; i++) m_slot[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset fetch_hold", fetch_hold, 0);
    chk("R1 reset decode_hold", decode_hold, 0);
    @(negedge clk); rst_n = 1;

    // R4: fewer than five writes; oldest slots still zero
    cyc(1, 32'h100, 0, 0, 0, 0);
    cyc(1, 32'h104, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 32'hF0, 32'hD0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // R2/R1 wrap: seven writes, then entry with same-cycle read and stray exec (R3, R5)
    for (int i = 0; i < 7; i++) cyc(1, 32'h2000 + i*4, 0, 0, 0, 0);
    cyc(1, 32'hDEAD, 1, 1, 32'hAA, 32'hBB);
    for (int i = 0; i < 4; i++) cyc(1, 32'hBAD0 + i, 1, 1, 0, 0);
    // R6: sixth read equals first
    first = m_slot[m_rp];
    cyc(0, 0, 1, 1, 0, 0);
    chk("R6 wrap read", first, 32'h2008);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0); // read outside debug still advances (R5)
    cyc(0, 0, 0, 0, 0, 0);

    // Random phases
    for (int r = 0; r < 60; r++) begin
      int n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) cyc($urandom % 4 != 0, $urandom, 0, 0, 0, 0);
      cyc($urandom % 2, $urandom, 1, $urandom % 2, $urandom, $urandom);
      for (int i = 0; i < 2 + ($urandom % 10); i++)
        cyc($urandom % 2, $urandom, 1, $urandom % 3 != 0, $urandom, $urandom);
      cyc(0, 0, 0, 0, 0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule